// File: doc/BRIEF.md
# Guest Exit Decision Unit

This unit sits beside a guest-mode execution pipeline and decides, for each decoded event, whether the guest must give up control to the supervising monitor. An event is one of four kinds: a classified instruction, an exception with its vector, an access to an I/O port, or a move to or from a control register. A control register move carries the register number, the direction and the index of the general register used.

The unit keeps its own configuration. This is a word of per-instruction enables and control-register write guards, a 32-bit exception mask, and a one-bit-per-port I/O map held in a small synchronous memory. One cycle after each event it raises a result strobe. With the strobe it gives an exit flag, a reason code and a qualification word that describes the exit.

Top module: `vmexit_decider`

## Requirements
- R1: After reset `done_o` and `exit_o` are low, and the control word and exception mask are cleared. With no configuration written, only the unconditional classes of R3 and a read of control register 3 cause an exit.
- R2: Every event accepted with `ev_valid` high gives exactly one `done_o` pulse on the following cycle, for every kind. Back-to-back events give back-to-back results in order. `ev_kind` encodes 0 = instruction, 1 = exception, 2 = port access, 3 = control-register move.
- R3: Instruction classes 0 (identification), 1 (page-table base read), 2 (model register read) and 3 (model register write) always exit, with reasons 10, 28, 31 and 32. Class 1 carries the qualification for register 3 read.
- R4: Classes 4 to 10 exit only when control word bits 0 to 6 are set, in that order. The classes are halt (reason 12), TLB entry invalidate (14), task-priority move (28, register number 8), debug-register move (29), monitor-wait (36), performance-counter read (15) and timestamp read (16).
- R5: For a control-register move, a write (`ev_dir` = 0) to register 0, 3 or 4 exits only when control word bit 7, 8 or 9 is set. A read of register 3 always exits. Register 8 in either direction exits when control word bit 2 is set. All other moves never exit. The reason is 28.
- R6: The qualification of a register-move exit holds the register number in bits [3:0] and the direction in bit 4 (0 = write to the control register). It holds the general register index in bits [11:8] and zeros elsewhere.
- R7: An exception with vector below 32 exits with reason 0 exactly when its mask bit is set, and its qualification is the vector.
- R8: An exception with vector 32 or above never exits, whatever the mask holds.
- R9: A port access exits with reason 30 exactly when the map bit of that port is set, and its qualification is the port number.
- R10: When a result does not exit, `reason_o` and `qual_o` are zero. Classes 11 to 15 never exit.
- R11: Configuration writes (`cfg_we`) choose their target with `cfg_sel`. A value of 0 loads the control word from `cfg_wdata[9:0]`, 1 loads the exception mask from `cfg_wdata`, and 2 writes `cfg_wdata[0]` into the port map at `cfg_addr`. A write is seen by events from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target |
| cfg_addr | input | PORT_W | Port map address |
| cfg_wdata | input | 32 | Configuration data |
| ev_valid | input | 1 | Event present |
| ev_kind | input | 2 | Event kind |
| ev_cls | input | 4 | Instruction class |
| ev_vec | input | 8 | Exception vector |
| ev_port | input | PORT_W | Port number |
| ev_crn | input | 4 | Control/debug register number |
| ev_dir | input | 1 | 1 = read from register, 0 = write |
| ev_gpr | input | 4 | General register index |
| done_o | output | 1 | Result strobe |
| exit_o | output | 1 | Event must leave guest mode |
| reason_o | output | 6 | Exit reason |
| qual_o | output | QUAL_W | Exit qualification |

## Verification
Every result, the port-map lookup included, is due at the first clock edge after the edge that accepts the event. The bench drives events just after a rising edge and reads results at the next falling edge. A scoreboard queue holds one expected entry per event in issue order. The monitor pops an entry only when `done_o` is high, so a late, early, missing or extra strobe all show up as mismatches. Configuration writes are placed one cycle before the events that depend on them, which checks the timing in R11.

// File: rtl/vmexit_decider.sv
module vmexit_decider #(
  parameter int PORT_W = 8,
  parameter int QUAL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PORT_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [3:0]        ev_cls,
  input  logic [7:0]        ev_vec,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [3:0]        ev_crn,
  input  logic              ev_dir,
  input  logic [3:0]        ev_gpr,
  output logic              done_o,
  output logic              exit_o,
  output logic [5:0]        reason_o,
  output logic [QUAL_W-1:0] qual_o
);
  localparam int NPORT = 1 << PORT_W;

  logic [6:0]  en_q;
  logic [2:0]  guard_q;
  logic [31:0] exc_q;
  logic        io_mem [NPORT];
  logic        io_bit_q;

  logic              d_exit;
  logic [5:0]        d_rs;
  logic [QUAL_W-1:0] d_ql;
  logic [QUAL_W-1:0] crq;

  logic              v_q, isio_q, ex_q;
  logic [5:0]        rs_q;
  logic [QUAL_W-1:0] ql_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0; guard_q <= '0; exc_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0) {guard_q, en_q} <= cfg_wdata[9:0];
      if (cfg_sel == 2'd1) exc_q <= cfg_wdata;
    end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == 2'd2) io_mem[cfg_addr] <= cfg_wdata[0];
    io_bit_q <= io_mem[ev_port];
  end

  assign crq = QUAL_W'({ev_gpr, 3'b000, ev_dir, ev_crn});

  always_comb begin
    d_exit = 1'b0;
    d_rs   = '0;
    d_ql   = '0;
    unique case (ev_kind)
      2'd0: unique case (ev_cls)
        4'd0:  begin d_exit = 1'b1;     d_rs = 6'd10; end
        4'd1:  begin d_exit = 1'b1;     d_rs = 6'd28;
                     d_ql = QUAL_W'({ev_gpr, 3'b000, 1'b1, 4'd3}); end
        4'd2:  begin d_exit = 1'b1;     d_rs = 6'd31; end
        4'd3:  begin d_exit = 1'b1;     d_rs = 6'd32; end
        4'd4:  begin d_exit = en_q[0];  d_rs = 6'd12; end
        4'd5:  begin d_exit = en_q[1];  d_rs = 6'd14; end
        4'd6:  begin d_exit = en_q[2];  d_rs = 6'd28;
                     d_ql = QUAL_W'({ev_gpr, 3'b000, ev_dir, 4'd8}); end
        4'd7:  begin d_exit = en_q[3];  d_rs = 6'd29; d_ql = crq; end
        4'd8:  begin d_exit = en_q[4];  d_rs = 6'd36; end
        4'd9:  begin d_exit = en_q[5];  d_rs = 6'd15; end
        4'd10: begin d_exit = en_q[6];  d_rs = 6'd16; end
        default: ;
      endcase
      2'd1: begin
        d_exit = (ev_vec < 8'd32) && exc_q[ev_vec[4:0]];
        d_rs   = 6'd0;
        d_ql   = QUAL_W'(ev_vec);
      end
      2'd2: begin
        d_rs = 6'd30;
        d_ql = QUAL_W'(ev_port);
      end
      default: begin
        d_rs = 6'd28;
        d_ql = crq;
        unique case (ev_crn)
          4'd0: d_exit = !ev_dir && guard_q[0];
          4'd3: d_exit = ev_dir || guard_q[1];
          4'd4: d_exit = !ev_dir && guard_q[2];
          4'd8: d_exit = en_q[2];
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v_q <= 1'b0; isio_q <= 1'b0; ex_q <= 1'b0; rs_q <= '0; ql_q <= '0;
    end else begin
      v_q    <= ev_valid;
      isio_q <= ev_valid && ev_kind == 2'd2;
      ex_q   <= ev_valid && d_exit;
      rs_q   <= d_rs;
      ql_q   <= d_ql;
    end

  assign done_o   = v_q;
  assign exit_o   = v_q && (isio_q ? io_bit_q : ex_q);
  assign reason_o = exit_o ? rs_q : '0;
  assign qual_o   = exit_o ? ql_q : '0;

  // R2
  result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> done_o);
  // R2
  no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !done_o);
  // R3
  ident_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == 2'd0 && ev_cls == 4'd0 |=> exit_o && reason_o == 6'd10);
  // R8
  high_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == 2'd1 && ev_vec >= 8'd32 |=> !exit_o);
  // R5
  cr3_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == 2'd3 && ev_crn == 4'd3 && ev_dir |=> exit_o && reason_o == 6'd28);
  // R10
  quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !exit_o |-> reason_o == 6'd0 && qual_o == '0);
endmodule

// File: tb/vmexit_decider_test.sv
module vmexit_decider_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [7:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic ev_valid = 0; logic [1:0] ev_kind = 0; logic [3:0] ev_cls = 0; logic [7:0] ev_vec = 0;
  logic [7:0] ev_port = 0; logic [3:0] ev_crn = 0; logic ev_dir = 0; logic [3:0] ev_gpr = 0;
  logic done_o, exit_o; logic [5:0] reason_o; logic [15:0] qual_o;

  int checks = 0, errors = 0;
  logic [22:0] expq[$];
  string tagq[$];
  logic [6:0] m_en = 0; logic [2:0] m_guard = 0; logic [31:0] m_exc = 0; logic [255:0] m_io = 0;

  always #5 clk = ~clk;

  vmexit_decider uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_cls(ev_cls), .ev_vec(ev_vec), .ev_port(ev_port), .ev_crn(ev_crn), .ev_dir(ev_dir),
    .ev_gpr(ev_gpr), .done_o(done_o), .exit_o(exit_o), .reason_o(reason_o), .qual_o(qual_o));

  function automatic logic [22:0] model(input logic [1:0] k, input logic [3:0] c,
      input logic [7:0] v, input logic [7:0] p, input logic [3:0] n, input logic d,
      input logic [3:0] g);
    logic ex; logic [5:0] rs; logic [15:0] q;
    logic [15:0] rq;
    rq = {4'h0, g, 3'b000, d, n};
    ex = 0; rs = 0; q = 0;
    if (k == 2'd1) begin
      ex = v < 32 && m_exc[v[4:0]]; q = {8'h00, v};
    end else if (k == 2'd2) begin
      ex = m_io[p]; rs = 30; q = {8'h00, p};
    end else if (k == 2'd3) begin
      rs = 28; q = rq;
      if (n == 0) ex = !d && m_guard[0];
      else if (n == 3) ex = d || m_guard[1];
      else if (n == 4) ex = !d && m_guard[2];
      else if (n == 8) ex = m_en[2];
    end else begin
      if (c <= 3) begin
        ex = 1;
        rs = (c == 0) ? 6'd10 : (c == 1) ? 6'd28 : (c == 2) ? 6'd31 : 6'd32;
        if (c == 1) q = {4'h0, g, 3'b000, 1'b1, 4'd3};
      end else if (c <= 10) begin
        ex = m_en[c - 4];
        case (c)
          4: rs = 12; 5: rs = 14; 6: rs = 28; 7: rs = 29; 8: rs = 36; 9: rs = 15;
          default: rs = 16;
        endcase
        if (c == 6) q = {4'h0, g, 3'b000, d, 4'd8};
        if (c == 7) q = rq;
      end
    end
    if (!ex) begin rs = 0; q = 0; end
    return {ex, rs, q};
  endfunction

  task automatic send(input logic [1:0] k, input logic [3:0] c, input logic [7:0] v,
      input logic [7:0] p, input logic [3:0] n, input logic d, input logic [3:0] g,
      input string tag);
    @(posedge clk); #2;
    cfg_we = 0; ev_valid = 1; ev_kind = k; ev_cls = c; ev_vec = v; ev_port = p;
    ev_crn = n; ev_dir = d; ev_gpr = g;
    expq.push_back(model(k, c, v, p, n, d, g));
    tagq.push_back(tag);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] a, input logic [31:0] w);
    @(posedge clk); #2;
    ev_valid = 0; cfg_we = 1; cfg_sel = s; cfg_addr = a; cfg_wdata = w;
    if (s == 0) begin m_en = w[6:0]; m_guard = w[9:7]; end
    else if (s == 1) m_exc = w;
    else m_io[a] = w[0];
  endtask

  task automatic idle(input int n);
    @(posedge clk); #2; ev_valid = 0; cfg_we = 0;
    repeat (n - 1) @(posedge clk);
  endtask

  always @(negedge clk) if (rst_n && done_o) begin
    checks++;
    if (expq.size() == 0) begin
      errors++; $display("FAIL R2 unexpected result: actual done=1 expected done=0");
    end else begin
      logic [22:0] e; string t;
      e = expq.pop_front(); t = tagq.pop_front();
      if ({exit_o, reason_o, qual_o} !== e) begin
        errors++;
        $display("FAIL %s actual exit=%0b reason=%0d qual=%h expected exit=%0b reason=%0d qual=%h",
                 t, exit_o, reason_o, qual_o, e[22], e[21:16], e[15:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    checks++;
    if (done_o !== 0 || exit_o !== 0) begin
      errors++; $display("FAIL R1 reset outputs: actual done=%0b exit=%0b expected 0 0", done_o, exit_o);
    end
    // R1: cleared configuration
    send(0, 4, 0, 0, 0, 0, 0, "R1");
    send(0, 10, 0, 0, 0, 0, 0, "R1");
    send(1, 0, 5, 0, 0, 0, 0, "R1");
    send(3, 0, 0, 0, 0, 0, 2, "R1");
    send(3, 0, 0, 0, 3, 1, 6, "R1");
    // R3 back-to-back with R2
    for (int c = 0; c < 4; c++) send(0, c[3:0], 0, 0, 0, 0, 4'd9, "R3");
    idle(2);
    // R4 both enable patterns
    cfg(0, 0, 32'h055);
    for (int c = 4; c <= 10; c++) send(0, c[3:0], 0, 0, 4'd5, 1, 4'd3, "R4");
    cfg(0, 0, 32'h02A);
    for (int c = 4; c <= 10; c++) send(0, c[3:0], 0, 0, 4'd2, 0, 4'd11, "R4");
    // R10 idle classes
    for (int c = 11; c < 16; c++) send(0, c[3:0], 0, 0, 0, 0, 0, "R10");
    // R5 / R6 register moves
    cfg(0, 0, 32'h000);
    send(3, 0, 0, 0, 0, 0, 1, "R5");
    send(3, 0, 0, 0, 4, 0, 1, "R5");
    cfg(0, 0, 32'h284);
    send(3, 0, 0, 0, 0, 0, 4'd7, "R6");
    send(3, 0, 0, 0, 3, 0, 4'd2, "R5");
    send(3, 0, 0, 0, 4, 0, 4'd15, "R6");
    send(3, 0, 0, 0, 0, 1, 4'd1, "R5");
    send(3, 0, 0, 0, 4, 1, 4'd1, "R5");
    send(3, 0, 0, 0, 3, 1, 4'd12, "R6");
    send(3, 0, 0, 0, 8, 1, 4'd5, "R6");
    send(3, 0, 0, 0, 8, 0, 4'd6, "R5");
    send(3, 0, 0, 0, 2, 0, 4'd3, "R5");
    cfg(0, 0, 32'h100);
    send(3, 0, 0, 0, 3, 0, 4'd8, "R11");
    send(3, 0, 0, 0, 8, 0, 4'd8, "R5");
    // R7 / R8 exceptions
    cfg(1, 0, 32'h8000_0401);
    send(1, 0, 0, 0, 0, 0, 0, "R7");
    send(1, 0, 1, 0, 0, 0, 0, "R7");
    send(1, 0, 10, 0, 0, 0, 0, "R7");
    send(1, 0, 31, 0, 0, 0, 0, "R7");
    send(1, 0, 32, 0, 0, 0, 0, "R8");
    cfg(1, 0, 32'hFFFF_FFFF);
    send(1, 0, 14, 0, 0, 0, 0, "R11");
    send(1, 0, 32, 0, 0, 0, 0, "R8");
    send(1, 0, 64, 0, 0, 0, 0, "R8");
    send(1, 0, 255, 0, 0, 0, 0, "R8");
    // R9 port map
    for (int p = 0; p < 256; p++) cfg(2, p[7:0], {31'd0, (p % 3) == 0});
    send(2, 0, 0, 8'd0, 0, 0, 0, "R9");
    send(2, 0, 0, 8'd1, 0, 0, 0, "R9");
    send(2, 0, 0, 8'd255, 0, 0, 0, "R9");
    send(2, 0, 0, 8'd254, 0, 0, 0, "R9");
    send(1, 0, 31, 0, 0, 0, 0, "R2");
    send(2, 0, 0, 8'd99, 0, 0, 0, "R9");
    cfg(2, 8'd99, 32'd0);
    send(2, 0, 0, 8'd99, 0, 0, 0, "R11");
    cfg(2, 8'd7, 32'd1);
    send(2, 0, 0, 8'd7, 0, 0, 0, "R11");
    idle(4);
    checks++;
    if (expq.size() != 0) begin
      errors++; $display("FAIL R2 missing results: actual %0d pending expected 0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule